// File: doc/BRIEF.md
# Phase Accumulator Oscillator with Staged Field Update

This block is a numerically controlled oscillator core. It holds a 48-bit phase accumulator. On every cycle marked as a valid sample, it adds a signed frequency word to the accumulator. It outputs an 18-bit phase word, which is the upper accumulator bits plus a programmable phase offset. The phase word is meant to drive a sine and cosine lookup further down the chain. Only a single clock is used.

New settings come in through a port shaped like a register write. A six-bit field mask picks which parts of the frequency word and the phase offset to take, and whether to clear the accumulator. This means any mix of fields can change in one request. A request pulse captures the selected parts into a staging copy, and the busy flag then rises. After a fixed commit latency, all staged values move into the running oscillator on a single clock edge, and busy falls. The accumulator therefore never runs with a half-written frequency. Several oscillators can be phase-aligned by committing a clear to each of them on the same edge.

Top module: `nco_rt_update`

## Requirements
- R1: After reset, busy is 0, phaseValid is 0, phaseOut is 0, and the committed frequency and offset are 0.
- R2: freqIn is a 48-bit two's-complement word. Each cycle with sampleEn high adds the committed frequency to the accumulator modulo 2^48. phaseOut equals accumulator bits 47:30 plus the committed offset, modulo 2^18. phaseValid is high in the cycle after a cycle with sampleEn high.
- R3: Mask bit 0 selects freqIn bits 15:0, bit 1 selects bits 31:16, and bit 2 selects bits 47:32. A frequency part whose mask bit is 0 keeps its committed value.
- R4: Mask bit 3 selects phaseIn bits 15:0 and mask bit 4 selects phaseIn bits 17:16 for the phase offset. phaseIn is an 18-bit two's-complement word. An offset part whose mask bit is 0 keeps its committed value.
- R5: When an update has mask bit 5 set and phaseRstIn at 1, the accumulator is cleared on the commit edge. When mask bit 5 is 0 or phaseRstIn is 0, the accumulator is not cleared. The clear is not repeated by later updates.
- R6: A request is accepted when updReq is high while busy is low. Data and mask are captured on the accepting edge. busy is high from the next cycle for exactly COMMIT_LAT cycles, and the new values take effect on the edge where busy falls.
- R7: A request raised while busy is high is ignored. It changes neither the busy timing nor the committed values, and it is not queued.
- R8: All selected fields take effect on the same edge. Until that edge, including the add made on that edge, the accumulator advances by the previously committed frequency.
- R9: While sampleEn is low the accumulator holds, and phaseValid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Advance the accumulator this cycle |
| freqIn | input | 48 | Requested frequency word, signed |
| phaseIn | input | 18 | Requested phase offset, signed |
| phaseRstIn | input | 1 | Requested accumulator clear |
| fieldEn | input | 6 | Field select mask for the update |
| updReq | input | 1 | Update request |
| busy | output | 1 | Update in progress |
| phaseOut | output | 18 | Phase word |
| phaseValid | output | 1 | phaseOut reflects a sample just taken |

## Verification
busy is due one cycle after the accepting edge and falls COMMIT_LAT edges after it. The committed values and any accumulator clear show on phaseOut right after that falling edge. A sample's effect on phaseOut and phaseValid is due one edge after the cycle in which sampleEn was high. The bench drives inputs on falling edges and counts each rising edge between stimulus and check, reading the outputs at the falling edge after the edge where the result is due. A bench model advances its expected accumulator by the committed frequency once per counted sample edge.

// File: rtl/nco_rt_pkg.sv
package nco_rt_pkg;
  localparam int FREQ_W      = 48;
  localparam int PHASE_W     = 18;
  localparam int SLICE_W     = 16;
  localparam int MASK_W      = 6;
  localparam int FREQ_SLICES = FREQ_W / SLICE_W;
  // mask bit positions for the offset and clear fields
  localparam int PH_LO_BIT   = FREQ_SLICES;
  localparam int PH_HI_BIT   = FREQ_SLICES + 1;
  localparam int RST_BIT     = FREQ_SLICES + 2;
  localparam int PH_HI_W     = PHASE_W - SLICE_W;

  typedef struct packed {
    logic stage;   // capture selected fields into staging
    logic commit;  // move staging into the running oscillator
  } ctrlStb_t;
endpackage

// File: rtl/nco_rt_ctrl.sv
module nco_rt_ctrl
  import nco_rt_pkg::*;
#(
  parameter int COMMIT_LAT = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     updReq,
  output logic     busy,
  output ctrlStb_t stb
);
  localparam int CNT_W = $clog2(COMMIT_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = updReq && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= CNT_W'(COMMIT_LAT);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy       = (cnt != '0);
  assign stb.stage  = accept;
  assign stb.commit = (cnt == CNT_W'(1));
endmodule

// File: rtl/nco_rt_datapath.sv
module nco_rt_datapath
  import nco_rt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic               sampleEn,
  input  logic [FREQ_W-1:0]  freqIn,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic               phaseRstIn,
  input  logic [MASK_W-1:0]  fieldEn,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               phaseValid
);
  logic [FREQ_W-1:0]  freqStage;
  logic [FREQ_W-1:0]  freqAct;
  logic [SLICE_W-1:0] offLoStage;
  logic [PH_HI_W-1:0] offHiStage;
  logic [PHASE_W-1:0] offAct;
  logic               rstPend;
  logic [FREQ_W-1:0]  acc;
  logic               validQ;

  // staging slices of the frequency word, one per mask bit
  for (genvar g = 0; g < FREQ_SLICES; g++) begin : g_freqSlice
    logic [SLICE_W-1:0] sliceQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sliceQ <= '0;
      end else if (stb.stage && fieldEn[g]) begin
        sliceQ <= freqIn[g*SLICE_W +: SLICE_W];
      end
    end
    assign freqStage[g*SLICE_W +: SLICE_W] = sliceQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offLoStage <= '0;
      offHiStage <= '0;
      rstPend    <= 1'b0;
    end else if (stb.stage) begin
      if (fieldEn[PH_LO_BIT]) offLoStage <= phaseIn[SLICE_W-1:0];
      if (fieldEn[PH_HI_BIT]) offHiStage <= phaseIn[PHASE_W-1:SLICE_W];
      rstPend <= fieldEn[RST_BIT] & phaseRstIn;
    end else if (stb.commit) begin
      rstPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqAct <= '0;
      offAct  <= '0;
    end else if (stb.commit) begin
      freqAct <= freqStage;
      offAct  <= {offHiStage, offLoStage};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= sampleEn;
      if (stb.commit && rstPend) begin
        acc <= '0;
      end else if (sampleEn) begin
        acc <= acc + freqAct;
      end
    end
  end

  assign phaseOut   = acc[FREQ_W-1 -: PHASE_W] + offAct;
  assign phaseValid = validQ;
endmodule

// File: rtl/nco_rt_update.sv
module nco_rt_update
  import nco_rt_pkg::*;
#(
  parameter int COMMIT_LAT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic [FREQ_W-1:0]  freqIn,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic               phaseRstIn,
  input  logic [MASK_W-1:0]  fieldEn,
  input  logic               updReq,
  output logic               busy,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               phaseValid
);
  ctrlStb_t ctrlStb;

  nco_rt_ctrl #(.COMMIT_LAT(COMMIT_LAT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .updReq (updReq),
    .busy   (busy),
    .stb    (ctrlStb)
  );

  nco_rt_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (ctrlStb),
    .sampleEn   (sampleEn),
    .freqIn     (freqIn),
    .phaseIn    (phaseIn),
    .phaseRstIn (phaseRstIn),
    .fieldEn    (fieldEn),
    .phaseOut   (phaseOut),
    .phaseValid (phaseValid)
  );
endmodule

// File: rtl/nco_rt_update_chk.sv
module nco_rt_update_chk
  import nco_rt_pkg::*;
#(
  parameter int COMMIT_LAT = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleEn,
  input logic               updReq,
  input logic               busy,
  input logic [PHASE_W-1:0] phaseOut,
  input logic               phaseValid
);
  localparam int RUN_W = $clog2(COMMIT_LAT + 1) + 1;

  // number of consecutive earlier cycles with busy high
  logic [RUN_W-1:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 1'b1 : '0;
  end

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updReq && !busy) |=> busy);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (busyRun < RUN_W'(COMMIT_LAT - 1))) |=> busy);

  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (busyRun == RUN_W'(COMMIT_LAT - 1))) |=> !busy);

  p_valid_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> phaseValid);

  p_valid_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> !phaseValid);

  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleEn && !busy) |=> $stable(phaseOut));
endmodule

bind nco_rt_update nco_rt_update_chk #(.COMMIT_LAT(COMMIT_LAT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleEn   (sampleEn),
  .updReq     (updReq),
  .busy       (busy),
  .phaseOut   (phaseOut),
  .phaseValid (phaseValid)
);

// File: tb/nco_rt_update_bench.sv
`timescale 1ns/1ps
module nco_rt_update_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b0;
  logic [47:0] freqIn = '0;
  logic [17:0] phaseIn = '0;
  logic        phaseRstIn = 1'b0;
  logic [5:0]  fieldEn = '0;
  logic        updReq = 1'b0;
  logic        busy;
  logic [17:0] phaseOut;
  logic        phaseValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of the requirements
  logic [47:0] expAcc  = '0;
  logic [47:0] expFreq = '0;
  logic [17:0] expOff  = '0;

  always #2 clk = ~clk;

  nco_rt_update #(.COMMIT_LAT(LAT)) u_nco_rt_update (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .freqIn(freqIn),
    .phaseIn(phaseIn), .phaseRstIn(phaseRstIn), .fieldEn(fieldEn),
    .updReq(updReq), .busy(busy), .phaseOut(phaseOut), .phaseValid(phaseValid)
  );

  function automatic logic [17:0] expPhase();
    return expAcc[47:30] + expOff;
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply a committed update to the model
  task automatic modelCommit(input logic [5:0] m, input logic [47:0] f,
                             input logic [17:0] p, input logic r);
    for (int i = 0; i < 3; i++)
      if (m[i]) expFreq[i*16 +: 16] = f[i*16 +: 16];
    if (m[3]) expOff[15:0]  = p[15:0];
    if (m[4]) expOff[17:16] = p[17:16];
    if (m[5] && r) expAcc = '0;
  endtask

  // update with sampling stopped; checks busy timing and result
  task automatic doUpdate(input string req, input logic [5:0] m, input logic [47:0] f,
                          input logic [17:0] p, input logic r);
    @(negedge clk);
    fieldEn = m; freqIn = f; phaseIn = p; phaseRstIn = r; updReq = 1'b1;
    @(negedge clk);
    updReq = 1'b0; freqIn = ~f; phaseIn = ~p; phaseRstIn = ~r; fieldEn = ~m;
    chk("R6 busy rise", 48'(busy), 48'd1);
    for (int i = 1; i < LAT; i++) begin
      @(negedge clk);
      chk("R6 busy held", 48'(busy), 48'd1);
    end
    @(negedge clk);
    chk("R6 busy fall", 48'(busy), 48'd0);
    modelCommit(m, f, p, r);
    chk(req, 48'(phaseOut), 48'(expPhase()));
  endtask

  task automatic runSamples(input int n);
    @(negedge clk);
    sampleEn = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    sampleEn = 1'b0;
    expAcc = expAcc + 48'(n) * expFreq;
    chk("R2 valid", 48'(phaseValid), 48'd1);
    chk("R2 phase", 48'(phaseOut), 48'(expPhase()));
    @(negedge clk);
    chk("R9 valid low", 48'(phaseValid), 48'd0);
    chk("R9 hold", 48'(phaseOut), 48'(expPhase()));
  endtask

  task automatic t_reset;
    chk("R1 busy", 48'(busy), 48'd0);
    chk("R1 valid", 48'(phaseValid), 48'd0);
    chk("R1 phase", 48'(phaseOut), 48'd0);
    runSamples(3);  // zero frequency after reset
    chk("R1 freq zero", 48'(phaseOut), 48'd0);
  endtask

  task automatic t_freqFull;
    doUpdate("R3 full freq", 6'b000111, 48'd3 << 30, 18'h0, 1'b0);
    runSamples(4);
    chk("R2 sum", 48'(phaseOut), 48'(expPhase()));
  endtask

  task automatic t_freqPartial;
    doUpdate("R3 upper slice only", 6'b000100, 48'h0002_FFFF_FFFF, 18'h3FFFF, 1'b0);
    chk("R3 freq kept", expFreq, 48'd11 << 30);
    runSamples(2);
  endtask

  task automatic t_offset;
    doUpdate("R4 offset low", 6'b001000, 48'hFFFF_FFFF_FFFF, 18'h3_0123, 1'b0);
    doUpdate("R4 offset high", 6'b010000, 48'h0, 18'h2_FFFF, 1'b0);
    chk("R4 offset value", 48'(expOff), 48'h2_0123);
    runSamples(1);
  endtask

  task automatic t_phaseRst;
    doUpdate("R5 mask bit clear", 6'b000000, 48'h0, 18'h0, 1'b1);
    doUpdate("R5 input low", 6'b100000, 48'h0, 18'h0, 1'b0);
    doUpdate("R5 clear", 6'b100000, 48'h0, 18'h0, 1'b1);
    chk("R5 phase is offset", 48'(phaseOut), 48'(expOff));
    runSamples(3);
    doUpdate("R5 one shot", 6'b000001, 48'h0, 18'h0, 1'b0);
  endtask

  task automatic t_wrap;
    doUpdate("R2 neg freq", 6'b111111, -(48'd1 << 30), 18'h0, 1'b1);
    runSamples(1);
    chk("R2 wrap", 48'(phaseOut), 48'h3FFFF);
  endtask

  task automatic t_busyIgnored;
    @(negedge clk);
    fieldEn = 6'b000111; freqIn = 48'd2 << 30; updReq = 1'b1;
    @(negedge clk);
    freqIn = 48'd9 << 30;  // updReq still high while busy
    chk("R6 busy rise", 48'(busy), 48'd1);
    @(negedge clk);
    updReq = 1'b0;
    for (int i = 2; i < LAT; i++) @(negedge clk);
    chk("R7 busy held", 48'(busy), 48'd1);
    @(negedge clk);
    chk("R7 busy fall on time", 48'(busy), 48'd0);
    @(negedge clk);
    chk("R7 not queued", 48'(busy), 48'd0);
    modelCommit(6'b000111, 48'd2 << 30, 18'h0, 1'b0);
    runSamples(1);
    chk("R7 first values kept", expFreq, 48'd2 << 30);
  endtask

  task automatic t_atomic;
    logic [47:0] oldF;
    oldF = expFreq;
    @(negedge clk);
    fieldEn = 6'b000111; freqIn = 48'd5 << 30; updReq = 1'b1; sampleEn = 1'b1;
    @(negedge clk);
    updReq = 1'b0;
    for (int i = 1; i <= LAT; i++) @(negedge clk);
    expAcc = expAcc + 48'(LAT + 1) * oldF;
    chk("R8 old freq until commit", 48'(phaseOut), 48'(expPhase()));
    modelCommit(6'b000111, 48'd5 << 30, 18'h0, 1'b0);
    @(negedge clk);
    sampleEn = 1'b0;
    expAcc = expAcc + expFreq;
    chk("R8 new freq after commit", 48'(phaseOut), 48'(expPhase()));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_freqFull();
    t_freqPartial();
    t_offset();
    t_phaseRst();
    t_wrap();
    t_busyIgnored();
    t_atomic();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule